// File: doc/BRIEF.md
# Battery-Backed Clock Register File

This block is the byte-wide register front end of a time-of-day clock with 256 bytes of battery RAM behind it. The bus reaches the array through two pairs of ports. In each pair, one port takes a register number and the other moves data to or from the register selected.

The lower pair addresses bytes 0x00 to 0x7F. The upper pair addresses bytes 0x80 to 0xFF. Writing a register number into the lower index port copies the selected byte into the lower data port's read value. When the number is a clock register, that copy is made in the same cycle as the clock registers themselves are refreshed.

A binary time counter moves forward on a one-cycle tick that arrives once per second. Register B selects how the time is shown: binary or packed BCD, and 12-hour or 24-hour. The block also models three flags:
- the update-in-progress flag in register A,
- the valid-RAM flag in register D,
- the interrupt flag register C, which clears when it is read.

Top module: `rtc_cmos_regfile`

## Requirements
- R1: `bus_port` value 0 is the lower index port and value 1 is the lower data port. Writing the index port stores the byte, and that port then reads it back. It also loads the lower data port's read value with byte `{0, index[6:0]}`. A data-port write stores the byte at `{0, index[6:0]}`, and the data port then reads back the written value.
- R2: `bus_port` value 2 is the upper index port and value 3 is the upper data port. Writing value 2 loads port 3's read value with byte `0x80 + data[6:0]`. Writing port 3 stores the byte at `0x80 + index[6:0]`. Neither upper port touches the lower bytes.
- R3: A lower-index write with `index[6:0] < 14` refreshes the clock registers: seconds at 0, minutes at 2, hours at 4, weekday at 6 (1 to 7, 1 after reset), date at 7, month at 8, and year modulo 100 at 9. It also sets register D (byte 13) to 0x80. The data port shows the refreshed value.
- R4: When register B (byte 11) has bit 2 set, fields are shown in binary. When bit 2 is clear, every field is shown in packed BCD, with the tens digit in bits 7:4.
- R5: When register B has bit 1 set, hours are shown as 0 to 23. When bit 1 is clear, hours are shown as the hour modulo 12, with bit 7 set from 12:00 onward.
- R6: A lower-index write with `index[6:0] = 0x0C` shows the current value of register C and then clears it to 0x00.
- R7: A data-port write while the lower index is 0x0B and `data[6] = 1` sets register C to 0xF0. A write to register B with bit 6 clear leaves register C unchanged.
- R8: One cycle after every `sec_tick`, the update-in-progress flag rises. It stays high for `UIP_HOLD_CYCLES` cycles and is read as bit 7 of register A (byte 10). The bit 7 written into register A is ignored.
- R9: Each `sec_tick` advances the time by one second. The tick carries through minutes, hours, weekday (7 wraps to 1), date, month and year. Months are 30 or 31 days long. February has 29 days when year modulo 4 is 0, and year 99 wraps to 0.
- R10: A data write to byte 0, 2, 4, 6, 7, 8 or 9 sets that field of the time counter. The value is decoded with the current register B modes. In 12-hour form, 12 stands for 0 and bit 7 adds 12.
- R11: Reset clears all 256 bytes and all four port read values. When `console_cfg` is 1 during reset, byte 0x17 is set to 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| console_cfg | input | 1 | Value placed in bit 0 of byte 0x17 at reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_port | input | 2 | Port offset: 0 lower index, 1 lower data, 2 upper index, 3 upper data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read value of the selected port |

## Verification
The time is loaded to the edge of a minute, a day, the end of February in both a leap and a common year, and the end of a century. One tick is then applied in each case, which separates plain increments, day carries, month lengths, the leap rule and the year wrap.

A single loaded hour of 13:45:30 is read back in all four combinations of the two mode bits. This separates the BCD and binary encodings from the 12-hour and 24-hour encodings, including the PM bit.

Register C is read twice after it has been forced to 0xF0, which separates read-to-clear from the forcing write. The flag in register A is sampled inside and after the hold window.

// File: rtl/rtc_pkg.sv
// Package: register numbers, time record and BCD helpers for the clock
// register file. Assumes 7-bit register indexes within each bank.
package rtc_pkg;

    localparam logic [6:0] REG_SEC  = 7'd0;
    localparam logic [6:0] REG_MIN  = 7'd2;
    localparam logic [6:0] REG_HOUR = 7'd4;
    localparam logic [6:0] REG_WDAY = 7'd6;
    localparam logic [6:0] REG_MDAY = 7'd7;
    localparam logic [6:0] REG_MON  = 7'd8;
    localparam logic [6:0] REG_YEAR = 7'd9;
    localparam logic [6:0] REG_A    = 7'd10;
    localparam logic [6:0] REG_B    = 7'd11;
    localparam logic [6:0] REG_C    = 7'd12;
    localparam logic [6:0] REG_D    = 7'd13;
    localparam logic [6:0] REFRESH_LIMIT = 7'd14;
    localparam int         N_FIELDS = 7;

    // Field slots used between codec and counter
    localparam logic [2:0] SL_SEC = 3'd0, SL_MIN = 3'd1, SL_HOUR = 3'd2,
                           SL_WDAY = 3'd3, SL_MDAY = 3'd4, SL_MON = 3'd5,
                           SL_YEAR = 3'd6;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    typedef struct packed {
        logic bin_mode;
        logic h24_mode;
    } rtc_mode_t;

    // Map a register index to {hit, slot}
    function automatic logic [3:0] slot_of(input logic [6:0] idx);
        case (idx)
            REG_SEC:  return {1'b1, SL_SEC};
            REG_MIN:  return {1'b1, SL_MIN};
            REG_HOUR: return {1'b1, SL_HOUR};
            REG_WDAY: return {1'b1, SL_WDAY};
            REG_MDAY: return {1'b1, SL_MDAY};
            REG_MON:  return {1'b1, SL_MON};
            REG_YEAR: return {1'b1, SL_YEAR};
            default:  return 4'b0000;
        endcase
    endfunction

    // Binary 0..99 to packed BCD
    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Packed BCD to binary
    function automatic logic [6:0] from_bcd(input logic [7:0] b);
        return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
    endfunction

    // Length of a month, leap year on year modulo 4
    function automatic logic [4:0] month_days(input logic [3:0] m, input logic [6:0] y);
        case (m)
            4'd2:                    return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_timekeeper.sv
// Binary time-of-day and calendar counter.
// Advances one second per tick pulse with all carries; a load of one field
// takes priority over a tick in the same cycle. Assumes loaded values are in range.
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ld_en,
    input  logic [2:0] ld_slot,
    input  logic [6:0] ld_val,
    output rtc_time_t  now
);

    rtc_time_t nxt;

    // Next time after one second, with every carry
    always_comb begin
        nxt = now;
        if (now.sec == 6'd59) begin
            nxt.sec = 6'd0;
            if (now.min == 6'd59) begin
                nxt.min = 6'd0;
                if (now.hour == 5'd23) begin
                    nxt.hour = 5'd0;
                    nxt.wday = (now.wday == 3'd6) ? 3'd0 : now.wday + 3'd1;
                    if (now.mday == month_days(now.mon, now.year)) begin
                        nxt.mday = 5'd1;
                        if (now.mon == 4'd12) begin
                            nxt.mon  = 4'd1;
                            nxt.year = (now.year == 7'd99) ? 7'd0 : now.year + 7'd1;
                        end else begin
                            nxt.mon = now.mon + 4'd1;
                        end
                    end else begin
                        nxt.mday = now.mday + 5'd1;
                    end
                end else begin
                    nxt.hour = now.hour + 5'd1;
                end
            end else begin
                nxt.min = now.min + 6'd1;
            end
        end else begin
            nxt.sec = now.sec + 6'd1;
        end
    end

    // Counter register: reset, field load, or tick advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now.sec  <= 6'd0;
            now.min  <= 6'd0;
            now.hour <= 5'd0;
            now.wday <= 3'd0;
            now.mday <= 5'd1;
            now.mon  <= 4'd1;
            now.year <= 7'd0;
        end else if (ld_en) begin
            case (ld_slot)
                SL_SEC:  now.sec  <= ld_val[5:0];
                SL_MIN:  now.min  <= ld_val[5:0];
                SL_HOUR: now.hour <= ld_val[4:0];
                SL_WDAY: now.wday <= ld_val[2:0];
                SL_MDAY: now.mday <= ld_val[4:0];
                SL_MON:  now.mon  <= ld_val[3:0];
                default: now.year <= ld_val;
            endcase
        end else if (tick) begin
            now <= nxt;
        end
    end

    // R9
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && now.sec == 6'd59) |=> (now.sec == 6'd0));

    // R9
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_en) |=> $stable(now));

endmodule

// File: rtl/rtc_field_codec.sv
// Converts between the binary time record and the byte forms software sees.
// Encodes every field under the current register B modes, and decodes one
// written byte back into a counter load. Purely combinational.
module rtc_field_codec
    import rtc_pkg::*;
(
    input  rtc_time_t                 cur,
    input  rtc_mode_t                 mode,
    input  logic [6:0]                wr_idx,
    input  logic [7:0]                wr_raw,
    output logic [N_FIELDS-1:0][7:0]  fmt,
    output logic                      ld_hit,
    output logic [2:0]                ld_slot,
    output logic [6:0]                ld_val
);

    logic [6:0] fval [N_FIELDS];
    logic       pm_flag;
    logic [3:0] slot_info;
    logic [6:0] full_dec;
    logic [6:0] low_dec;
    logic [6:0] hour12;

    // Byte encoding under the current number mode
    function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    // Binary value of each field before encoding
    always_comb begin
        pm_flag = !mode.h24_mode && (cur.hour >= 5'd12);
        fval[0] = {1'b0, cur.sec};
        fval[1] = {1'b0, cur.min};
        if (mode.h24_mode)
            fval[2] = {2'b00, cur.hour};
        else
            fval[2] = (cur.hour >= 5'd12) ? {2'b00, cur.hour - 5'd12} : {2'b00, cur.hour};
        fval[3] = {4'b0000, cur.wday} + 7'd1;
        fval[4] = {2'b00, cur.mday};
        fval[5] = {3'b000, cur.mon};
        fval[6] = cur.year;
    end

    // One encoder per field; the hour carries the PM bit
    for (genvar f = 0; f < N_FIELDS; f++) begin : g_enc
        if (f == 2) begin : g_hour
            assign fmt[f] = enc(fval[f], mode.bin_mode) | {pm_flag, 7'b0};
        end else begin : g_plain
            assign fmt[f] = enc(fval[f], mode.bin_mode);
        end
    end

    // Decode of a written byte into a counter load
    always_comb begin
        slot_info = slot_of(wr_idx);
        ld_hit    = slot_info[3];
        ld_slot   = slot_info[2:0];
        full_dec  = mode.bin_mode ? wr_raw[6:0] : from_bcd(wr_raw);
        low_dec   = mode.bin_mode ? wr_raw[6:0] : from_bcd({1'b0, wr_raw[6:0]});
        hour12    = ((low_dec == 7'd12) ? 7'd0 : low_dec) + (wr_raw[7] ? 7'd12 : 7'd0);
        case (ld_slot)
            SL_HOUR: ld_val = mode.h24_mode ? full_dec : hour12;
            SL_WDAY: ld_val = full_dec - 7'd1;
            default: ld_val = full_dec;
        endcase
    end

endmodule

// File: rtl/rtc_uip_timer.sv
// Update-in-progress flag: raised by each second tick and held for a fixed
// number of clock cycles. Assumes HOLD_CYCLES >= 2.
module rtc_uip_timer #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic uip
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Flag and hold counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uip    <= 1'b0;
            remain <= '0;
        end else if (tick) begin
            uip    <= 1'b1;
            remain <= CNT_W'(HOLD_CYCLES - 1);
        end else if (uip) begin
            if (remain == '0)
                uip <= 1'b0;
            else
                remain <= remain - 1'b1;
        end
    end

    // R8
    uip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> $past(tick));

    // R8
    uip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> uip);

endmodule

// File: rtl/rtc_cmos_regfile.sv
// Clock register file top: two index/data port pairs in front of a
// 256-byte array. Refreshes the clock registers when a low index is
// written, models registers A, C and D. Assumes MEM_DEPTH = 256, with
// 7-bit indexes in each bank.
module rtc_cmos_regfile
    import rtc_pkg::*;
#(
    parameter int         MEM_DEPTH       = 256,
    parameter int         UIP_HOLD_CYCLES = 16,
    parameter logic [7:0] CFG_BYTE        = 8'h17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       console_cfg,
    input  logic       sec_tick,
    input  logic       bus_wr,
    input  logic [1:0] bus_port,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);

    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam int N_PORT = 4;

    logic [7:0]                mem [MEM_DEPTH];
    logic [N_PORT-1:0][7:0]    port_q;
    rtc_time_t                 now;
    rtc_mode_t                 mode;
    logic [N_FIELDS-1:0][7:0]  fmt;
    logic                      ld_hit;
    logic [2:0]                ld_slot;
    logic [6:0]                ld_val;
    logic                      uip;
    logic [6:0]                view_idx;
    logic [3:0]                view_slot;
    logic [7:0]                lo_view;
    logic                      wr_idx_lo;
    logic                      wr_dat_lo;
    logic                      wr_idx_hi;
    logic                      wr_dat_hi;
    logic                      refresh;

    assign wr_idx_lo = bus_wr && (bus_port == 2'd0);
    assign wr_dat_lo = bus_wr && (bus_port == 2'd1);
    assign wr_idx_hi = bus_wr && (bus_port == 2'd2);
    assign wr_dat_hi = bus_wr && (bus_port == 2'd3);
    assign mode.bin_mode = mem[ADDR_W'(REG_B)][2];
    assign mode.h24_mode = mem[ADDR_W'(REG_B)][1];
    assign view_idx  = bus_wdata[6:0];
    assign refresh   = wr_idx_lo && (view_idx < REFRESH_LIMIT);
    assign bus_rdata = port_q[bus_port];

    rtc_uip_timer #(.HOLD_CYCLES(UIP_HOLD_CYCLES)) u_uip (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick),
        .uip   (uip)
    );

    rtc_field_codec u_codec (
        .cur     (now),
        .mode    (mode),
        .wr_idx  (port_q[0][6:0]),
        .wr_raw  (bus_wdata),
        .fmt     (fmt),
        .ld_hit  (ld_hit),
        .ld_slot (ld_slot),
        .ld_val  (ld_val)
    );

    rtc_timekeeper u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .ld_en   (wr_dat_lo && ld_hit),
        .ld_slot (ld_slot),
        .ld_val  (ld_val),
        .now     (now)
    );

    // Value the lower data port takes when an index is written
    always_comb begin
        view_slot = slot_of(view_idx);
        if (view_slot[3])
            lo_view = fmt[view_slot[2:0]];
        else if (view_idx == REG_D)
            lo_view = 8'h80;
        else if (view_idx == REG_A)
            lo_view = {uip, mem[ADDR_W'(REG_A)][6:0]};
        else
            lo_view = mem[{1'b0, view_idx}];
    end

    // Byte array: reset fill, refresh, read-to-clear and data writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++)
                mem[i] <= 8'h00;
            mem[CFG_BYTE] <= {7'b0, console_cfg};
        end else begin
            if (refresh) begin
                mem[ADDR_W'(REG_SEC)]  <= fmt[SL_SEC];
                mem[ADDR_W'(REG_MIN)]  <= fmt[SL_MIN];
                mem[ADDR_W'(REG_HOUR)] <= fmt[SL_HOUR];
                mem[ADDR_W'(REG_WDAY)] <= fmt[SL_WDAY];
                mem[ADDR_W'(REG_MDAY)] <= fmt[SL_MDAY];
                mem[ADDR_W'(REG_MON)]  <= fmt[SL_MON];
                mem[ADDR_W'(REG_YEAR)] <= fmt[SL_YEAR];
                mem[ADDR_W'(REG_D)]    <= 8'h80;
            end
            if (wr_idx_lo && view_idx == REG_C)
                mem[ADDR_W'(REG_C)] <= 8'h00;
            if (wr_dat_lo) begin
                if (port_q[0][6:0] == REG_B && bus_wdata[6])
                    mem[ADDR_W'(REG_C)] <= 8'hF0;
                mem[{1'b0, port_q[0][6:0]}] <= bus_wdata;
            end
            if (wr_dat_hi)
                mem[{1'b1, port_q[2][6:0]}] <= bus_wdata;
        end
    end

    // Port read values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else if (wr_idx_lo) begin
            port_q[0] <= bus_wdata;
            port_q[1] <= lo_view;
        end else if (wr_dat_lo) begin
            port_q[1] <= bus_wdata;
        end else if (wr_idx_hi) begin
            port_q[2] <= bus_wdata;
            port_q[3] <= mem[{1'b1, bus_wdata[6:0]}];
        end else if (wr_dat_hi) begin
            port_q[3] <= bus_wdata;
        end
    end

    // R6
    regc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx_lo && view_idx == REG_C) |=> (mem[ADDR_W'(REG_C)] == 8'h00));

    // R7
    regc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat_lo && port_q[0][6:0] == REG_B && bus_wdata[6])
        |=> (mem[ADDR_W'(REG_C)] == 8'hF0));

    // R3
    regd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (mem[ADDR_W'(REG_D)] == 8'h80));

    // R2
    upper_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat_hi || wr_idx_hi) |=> $stable(port_q[1]));

endmodule

// File: tb/tb_rtc_cmos_regfile.sv
// Scoreboard bench: driver tasks queue expected port values, a monitor
// process pops and compares them against the read port.
module tb_rtc_cmos_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       console_cfg = 1'b1;
    logic       sec_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_port = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] q_val [$];
    logic [1:0] q_sel [$];
    string      q_tag [$];
    event       smp_ev;

    always #4 clk = ~clk;

    rtc_cmos_regfile #(.UIP_HOLD_CYCLES(16)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .console_cfg (console_cfg),
        .sec_tick    (sec_tick),
        .bus_wr      (bus_wr),
        .bus_port    (bus_port),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata)
    );

    task automatic wr(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_port = p; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic expect_port(input logic [1:0] p, input logic [7:0] v, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_port = p;
        q_val.push_back(v); q_sel.push_back(p); q_tag.push_back(tag);
        #2;
        -> smp_ev;
        #1;
    endtask

    task automatic set_reg(input logic [6:0] idx, input logic [7:0] v);
        wr(2'd0, {1'b0, idx});
        wr(2'd1, v);
    endtask

    task automatic read_lo(input logic [6:0] idx, input logic [7:0] v, input string tag);
        wr(2'd0, {1'b0, idx});
        expect_port(2'd1, v, tag);
    endtask

    // Monitor: compare each queued expectation with the read port
    initial begin
        forever begin
            @(smp_ev);
            checks++;
            if (bus_rdata !== q_val[0]) begin
                errors++;
                $display("FAIL %s: port %0d read %02h expected %02h",
                         q_tag[0], q_sel[0], bus_rdata, q_val[0]);
            end
            void'(q_val.pop_front());
            void'(q_sel.pop_front());
            void'(q_tag.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state and configuration byte
        expect_port(2'd0, 8'h00, "R11");
        expect_port(2'd1, 8'h00, "R11");
        expect_port(2'd3, 8'h00, "R11");
        read_lo(7'h17, 8'h01, "R11");
        read_lo(7'h30, 8'h00, "R11");

        // R1 index echo and data store
        expect_port(2'd0, 8'h30, "R1");
        set_reg(7'h20, 8'h5A);
        expect_port(2'd1, 8'h5A, "R1");
        read_lo(7'h20, 8'h5A, "R1");

        // R3 refresh, binary 24-hour
        set_reg(7'h0B, 8'h06);
        repeat (5) tick();
        read_lo(7'h00, 8'd5, "R3");
        read_lo(7'h06, 8'd1, "R3");
        read_lo(7'h07, 8'd1, "R3");
        read_lo(7'h08, 8'd1, "R3");
        read_lo(7'h09, 8'd0, "R3");
        read_lo(7'h0D, 8'h80, "R3");

        // R9 leap February
        set_reg(7'h09, 8'd4); set_reg(7'h08, 8'd2); set_reg(7'h07, 8'd28);
        set_reg(7'h04, 8'd23); set_reg(7'h02, 8'd59); set_reg(7'h00, 8'd59);
        tick();
        read_lo(7'h07, 8'd29, "R9");
        read_lo(7'h08, 8'd2, "R9");
        read_lo(7'h04, 8'd0, "R9");
        read_lo(7'h00, 8'd0, "R9");

        // R9 common-year February
        set_reg(7'h09, 8'd1); set_reg(7'h08, 8'd2); set_reg(7'h07, 8'd28);
        set_reg(7'h04, 8'd23); set_reg(7'h02, 8'd59); set_reg(7'h00, 8'd59);
        tick();
        read_lo(7'h07, 8'd1, "R9");
        read_lo(7'h08, 8'd3, "R9");

        // R9 century and weekday wrap
        set_reg(7'h09, 8'd99); set_reg(7'h08, 8'd12); set_reg(7'h07, 8'd31);
        set_reg(7'h06, 8'd7); set_reg(7'h04, 8'd23); set_reg(7'h02, 8'd59);
        set_reg(7'h00, 8'd59);
        tick();
        read_lo(7'h09, 8'd0, "R9");
        read_lo(7'h08, 8'd1, "R9");
        read_lo(7'h07, 8'd1, "R9");
        read_lo(7'h06, 8'd1, "R9");
        read_lo(7'h02, 8'd0, "R9");

        // R9 minute carry only
        set_reg(7'h02, 8'd10); set_reg(7'h00, 8'd59);
        tick();
        read_lo(7'h02, 8'd11, "R9");
        read_lo(7'h04, 8'd0, "R9");

        // R4 R5 R10 formats of 13:45:30
        set_reg(7'h0B, 8'h00);
        set_reg(7'h02, 8'h45); set_reg(7'h04, 8'h81); set_reg(7'h00, 8'h30);
        read_lo(7'h04, 8'h81, "R5");
        read_lo(7'h02, 8'h45, "R4");
        read_lo(7'h00, 8'h30, "R4");
        set_reg(7'h0B, 8'h02);
        read_lo(7'h04, 8'h13, "R5");
        set_reg(7'h0B, 8'h04);
        read_lo(7'h04, 8'h81, "R5");
        read_lo(7'h02, 8'h2D, "R4");
        set_reg(7'h0B, 8'h06);
        read_lo(7'h04, 8'h0D, "R5");

        // R10 BCD year and 12-hour midnight and noon
        set_reg(7'h0B, 8'h00);
        set_reg(7'h09, 8'h99);
        read_lo(7'h09, 8'h99, "R10");
        set_reg(7'h04, 8'h12);
        set_reg(7'h0B, 8'h06);
        read_lo(7'h09, 8'h63, "R10");
        read_lo(7'h04, 8'h00, "R10");
        set_reg(7'h0B, 8'h00);
        set_reg(7'h04, 8'h92);
        set_reg(7'h0B, 8'h06);
        read_lo(7'h04, 8'h0C, "R10");

        // R7 R6 register C
        set_reg(7'h0B, 8'h46);
        read_lo(7'h0C, 8'hF0, "R7");
        read_lo(7'h0C, 8'h00, "R6");
        set_reg(7'h0C, 8'h33);
        read_lo(7'h0C, 8'h33, "R6");
        read_lo(7'h0C, 8'h00, "R6");
        set_reg(7'h0B, 8'h06);
        read_lo(7'h0C, 8'h00, "R7");

        // R2 upper bank
        wr(2'd2, 8'h85);
        wr(2'd3, 8'hA5);
        expect_port(2'd3, 8'hA5, "R2");
        wr(2'd2, 8'h10);
        expect_port(2'd3, 8'h00, "R2");
        wr(2'd2, 8'h05);
        expect_port(2'd3, 8'hA5, "R2");
        expect_port(2'd2, 8'h05, "R2");
        read_lo(7'h05, 8'h00, "R2");

        // R8 update-in-progress flag
        set_reg(7'h0A, 8'hA6);
        read_lo(7'h0A, 8'h26, "R8");
        tick();
        wr(2'd0, 8'h0A);
        expect_port(2'd1, 8'hA6, "R8");
        repeat (20) @(negedge clk);
        read_lo(7'h0A, 8'h26, "R8");

        wait (q_val.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule